// File: doc/BRIEF.md
# Asynchronous Error Trap Status Capture

This block watches a set of per-cycle uncorrectable-error strobes and decides whether they raise an asynchronous data error trap. A handler-mode control bit picks the trap class. With the bit clear, instruction-side or asynchronous uncorrectable errors give a single-class trap. With the bit set, instruction-side uncorrectable errors, instruction access errors or data access errors give a multiple-class trap. Each trap is reported as a one-cycle pulse on its own output.

Alongside the pulse, the block keeps a small status register that software can only read. A single-class trap records three things: how the trapped instruction ended, the privilege level in force just before the trap, and a cleared set of source flags. A multiple-class trap only sets the source flags for the causes that were present. The register is read through a plain registered read port that is as wide as a data word, and every bit above the six defined ones reads as zero.

Top module: `err_trap_capture`

## Requirements
- R1: With handler_mode_i = 0, a cycle in which ev_instr_unc_i or ev_async_unc_i is high produces a one-cycle pulse on trap_single_o in the following cycle; ev_iaccess_i and ev_daccess_i alone raise no trap in this mode.
- R2: With handler_mode_i = 1, a cycle in which ev_instr_unc_i, ev_iaccess_i or ev_daccess_i is high produces a one-cycle pulse on trap_multi_o in the following cycle; ev_async_unc_i alone raises no trap in this mode.
- R3: On a single-class trap with wdog_to_i low, status bits 5:4 load end_method_i (00 precise, 01 retryable but not precise, 10 reserved, 11 not retryable), and the value is stored as given, 10 included.
- R4: On a single-class trap with wdog_to_i high, status bits 5:4 load 00 whatever end_method_i holds.
- R5: On a single-class trap, status bit 3 loads priv_i, or loads 1 when priv_corrupt_i is high.
- R6: On a single-class trap, status bit 2 (data access source), bit 1 (instruction access source) and bit 0 (instruction-side uncorrectable source) are all cleared.
- R7: On a multiple-class trap, each of bits 2:0 is set when its own cause was present and otherwise keeps its value; bits 5:3 keep their values.
- R8: At most one trap pulse is high in any cycle, and in a cycle with no trap pulse the status register keeps its value.
- R9: While rst is high, both trap pulses are low and the status register and rd_data_o are cleared to zero.
- R10: The status register updates on the clock edge that ends the trap pulse. rd_data_o shows the status value, zero-extended, one cycle after rd_en_i is sampled high, so a new value shows one cycle after the update. It shows zero after rd_en_i is sampled low, and bits DATA_W-1:6 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| handler_mode_i | input | 1 | Trap class select: 0 single, 1 multiple |
| ev_instr_unc_i | input | 1 | Instruction-side uncorrectable error strobe |
| ev_async_unc_i | input | 1 | Asynchronous uncorrectable error strobe |
| ev_iaccess_i | input | 1 | Instruction access error strobe |
| ev_daccess_i | input | 1 | Data access error strobe |
| end_method_i | input | 2 | End-method code of the trapped instruction |
| wdog_to_i | input | 1 | Watchdog timeout accompanies the event |
| priv_i | input | 1 | Privilege bit just before the event |
| priv_corrupt_i | input | 1 | Privilege bit is known to be corrupted |
| rd_en_i | input | 1 | Read request for the status register |
| trap_single_o | output | 1 | Single-class trap pulse |
| trap_multi_o | output | 1 | Multiple-class trap pulse |
| rd_data_o | output | DATA_W | Registered read data, status in bits 5:0 |

## Verification
The bench sends one event at a time and each event leaves a known change in the status register. A wrong captured field or source flag shows on rd_data_o three cycles after the event strobe, and the bench reads it there. The events come in a chain, so a flag that was wrongly set, cleared or kept also breaks the value expected after the next event. A wrong class decision shows sooner, one cycle after the strobe, as a pulse on the wrong output or no pulse at all.

// File: rtl/err_trap_pkg.sv
package err_trap_pkg;

  localparam int STAT_W  = 6;
  localparam int EM_W    = 2;
  localparam int SRC_W   = 3;

  // bit positions inside the status register
  localparam int POS_SRC_IUNC = 0;
  localparam int POS_SRC_IACC = 1;
  localparam int POS_SRC_DACC = 2;
  localparam int POS_PRIV     = 3;
  localparam int POS_EM_LO    = 4;
  localparam int POS_EM_HI    = 5;

  typedef enum logic [EM_W-1:0] {
    EM_PRECISE   = 2'b00,
    EM_RETRY     = 2'b01,
    EM_RESERVED  = 2'b10,
    EM_NORETRY   = 2'b11
  } end_method_e;

  typedef struct packed {
    logic [EM_W-1:0]  em;
    logic             priv;
    logic [SRC_W-1:0] cause;  // {dacc, iacc, iunc}
  } trap_capture_t;

endpackage

// File: rtl/err_trap_classify.sv
module err_trap_classify
  import err_trap_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            handler_mode_i,
  input  logic            ev_instr_unc_i,
  input  logic            ev_async_unc_i,
  input  logic            ev_iaccess_i,
  input  logic            ev_daccess_i,
  input  logic [EM_W-1:0] end_method_i,
  input  logic            wdog_to_i,
  input  logic            priv_i,
  input  logic            priv_corrupt_i,
  output logic            single_q_o,
  output logic            multi_q_o,
  output trap_capture_t   cap_q_o
);

  logic          want_single;
  logic          want_multi;
  trap_capture_t cap_d;

  // the mode bit alone selects the class, so both can never fire together
  always_comb begin
    want_single = !handler_mode_i && (ev_instr_unc_i || ev_async_unc_i);
    want_multi  =  handler_mode_i && (ev_instr_unc_i || ev_iaccess_i || ev_daccess_i);
  end

  always_comb begin
    cap_d.em    = wdog_to_i ? EM_PRECISE : end_method_i;
    cap_d.priv  = priv_corrupt_i ? 1'b1 : priv_i;
    cap_d.cause = {ev_daccess_i, ev_iaccess_i, ev_instr_unc_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      single_q_o <= 1'b0;
      multi_q_o  <= 1'b0;
      cap_q_o    <= '0;
    end else begin
      single_q_o <= want_single;
      multi_q_o  <= want_multi;
      cap_q_o    <= cap_d;
    end
  end

endmodule

// File: rtl/err_trap_status.sv
module err_trap_status
  import err_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              single_i,
  input  logic              multi_i,
  input  trap_capture_t     cap_i,
  output logic [STAT_W-1:0] status_o
);

  logic [EM_W-1:0]  em_q;
  logic             priv_q;
  logic [SRC_W-1:0] src_q;

  // end-method and privilege fields: loaded only by a single-class trap
  always_ff @(posedge clk) begin
    if (rst) begin
      em_q   <= '0;
      priv_q <= 1'b0;
    end else if (single_i) begin
      em_q   <= cap_i.em;
      priv_q <= cap_i.priv;
    end
  end

  // source flags: cleared by a single trap, set per own cause by a multiple trap
  for (genvar k = 0; k < SRC_W; k++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        src_q[k] <= 1'b0;
      end else if (single_i) begin
        src_q[k] <= 1'b0;
      end else if (multi_i && cap_i.cause[k]) begin
        src_q[k] <= 1'b1;
      end
    end
  end

  always_comb begin
    status_o                     = '0;
    status_o[POS_EM_HI:POS_EM_LO] = em_q;
    status_o[POS_PRIV]           = priv_q;
    status_o[POS_SRC_DACC]       = src_q[2];
    status_o[POS_SRC_IACC]       = src_q[1];
    status_o[POS_SRC_IUNC]       = src_q[0];
  end

endmodule

// File: rtl/err_trap_rdport.sv
module err_trap_rdport
  import err_trap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int PAD_W = DATA_W - STAT_W;

  logic [DATA_W-1:0] word;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = {{PAD_W{1'b0}}, status_i};
    end else begin : g_nopad
      assign word = status_i[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else begin
      rd_data_o <= rd_en_i ? word : '0;
    end
  end

endmodule

// File: rtl/err_trap_capture.sv
module err_trap_capture
  import err_trap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              handler_mode_i,
  input  logic              ev_instr_unc_i,
  input  logic              ev_async_unc_i,
  input  logic              ev_iaccess_i,
  input  logic              ev_daccess_i,
  input  logic [1:0]        end_method_i,
  input  logic              wdog_to_i,
  input  logic              priv_i,
  input  logic              priv_corrupt_i,
  input  logic              rd_en_i,
  output logic              trap_single_o,
  output logic              trap_multi_o,
  output logic [DATA_W-1:0] rd_data_o
);

  trap_capture_t     cap_q;
  logic [STAT_W-1:0] status_q;

  err_trap_classify u_classify (
    .clk            (clk),
    .rst            (rst),
    .handler_mode_i (handler_mode_i),
    .ev_instr_unc_i (ev_instr_unc_i),
    .ev_async_unc_i (ev_async_unc_i),
    .ev_iaccess_i   (ev_iaccess_i),
    .ev_daccess_i   (ev_daccess_i),
    .end_method_i   (end_method_i),
    .wdog_to_i      (wdog_to_i),
    .priv_i         (priv_i),
    .priv_corrupt_i (priv_corrupt_i),
    .single_q_o     (trap_single_o),
    .multi_q_o      (trap_multi_o),
    .cap_q_o        (cap_q)
  );

  err_trap_status u_status (
    .clk      (clk),
    .rst      (rst),
    .single_i (trap_single_o),
    .multi_i  (trap_multi_o),
    .cap_i    (cap_q),
    .status_o (status_q)
  );

  err_trap_rdport #(.DATA_W(DATA_W)) u_rdport (
    .clk       (clk),
    .rst       (rst),
    .rd_en_i   (rd_en_i),
    .status_i  (status_q),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/err_trap_capture_chk.sv
module err_trap_capture_chk
  import err_trap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              trap_single_o,
  input logic              trap_multi_o,
  input logic [2:0]        cause_q,
  input logic [STAT_W-1:0] status_q,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o
);

  // R8: never both pulses
  a_r8_one_pulse: assert property (@(posedge clk) disable iff (rst)
    !(trap_single_o && trap_multi_o));

  // R6: single trap leaves all source flags cleared
  a_r6_single_clears_src: assert property (@(posedge clk) disable iff (rst)
    trap_single_o |=> (status_q[2:0] == 3'b000));

  // R7: multiple trap keeps upper fields
  a_r7_multi_keeps_upper: assert property (@(posedge clk) disable iff (rst)
    trap_multi_o |=> (status_q[5:3] == $past(status_q[5:3])));

  // R7: multiple trap sets the flag of every cause present
  a_r7_multi_sets_cause: assert property (@(posedge clk) disable iff (rst)
    trap_multi_o |=> ((status_q[2:0] & $past(cause_q)) == $past(cause_q)));

  // R8: no trap, no change
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!trap_single_o && !trap_multi_o) |=> $stable(status_q));

  // R10: read data mirrors the status one cycle after the request
  a_r10_read_mirror: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en_i)) |-> (rd_data_o[STAT_W-1:0] == $past(status_q)));

  // R10: bits above the status field stay zero
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[DATA_W-1:STAT_W] == '0);

endmodule

bind err_trap_capture err_trap_capture_chk #(.DATA_W(DATA_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .trap_single_o (trap_single_o),
  .trap_multi_o  (trap_multi_o),
  .cause_q       (cap_q.cause),
  .status_q      (status_q),
  .rd_en_i       (rd_en_i),
  .rd_data_o     (rd_data_o)
);

// File: tb/err_trap_capture_tb_top.sv
module err_trap_capture_tb_top;

  localparam int DATA_W = 32;
  localparam int NVEC   = 12;

  logic clk = 1'b0;
  logic rst;
  logic handler_mode_i, ev_instr_unc_i, ev_async_unc_i, ev_iaccess_i, ev_daccess_i;
  logic [1:0] end_method_i;
  logic wdog_to_i, priv_i, priv_corrupt_i, rd_en_i;
  logic trap_single_o, trap_multi_o;
  logic [DATA_W-1:0] rd_data_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  err_trap_capture #(.DATA_W(DATA_W)) dut_i (.*);

  // [17] mode [16:13] {iunc,aunc,iacc,dacc} [12:11] em [10] wdog [9] priv
  // [8] priv_corrupt [7] exp single [6] exp multi [5:0] exp status after
  localparam logic [17:0] VEC [NVEC] = '{
    18'b0_1000_01_0_1_0_1_0_011000,  // single, retryable, priv 1
    18'b1_0001_00_0_0_0_0_1_011100,  // multi, data access
    18'b1_1010_11_0_0_0_0_1_011111,  // multi, iunc + iacc, em ignored
    18'b0_0100_11_0_0_0_1_0_110000,  // single by async, not retryable
    18'b1_0100_01_0_1_0_0_0_110000,  // async alone in mode 1: nothing
    18'b0_0011_01_0_1_0_0_0_110000,  // access errors in mode 0: nothing
    18'b0_1000_10_1_0_0_1_0_000000,  // watchdog forces em 00
    18'b1_1000_00_0_0_0_0_1_000001,  // multi, iunc only
    18'b0_1100_00_0_0_1_1_0_001000,  // corrupted priv forces 1
    18'b1_1111_00_0_0_0_0_1_001111,  // multi, all causes
    18'b0_1000_01_0_1_1_1_0_011000,  // corrupted with priv 1
    18'b0_1111_10_0_0_0_1_0_100000   // single, reserved em stored
  };

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    handler_mode_i = 1'b0; ev_instr_unc_i = 1'b0; ev_async_unc_i = 1'b0;
    ev_iaccess_i = 1'b0; ev_daccess_i = 1'b0; end_method_i = 2'b00;
    wdog_to_i = 1'b0; priv_i = 1'b0; priv_corrupt_i = 1'b0;
  endtask

  initial begin
    logic [DATA_W-1:0] prev;
    logic [DATA_W-1:0] expw;
    rst = 1'b1;
    rd_en_i = 1'b1;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!trap_single_o && !trap_multi_o, "R9 pulses in reset", {31'b0, trap_single_o | trap_multi_o}, 0);
    chk(rd_data_o == '0, "R9 read data in reset", rd_data_o, 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(rd_data_o == '0, "R9 status after reset", rd_data_o, 0);
    prev = '0;

    for (int i = 0; i < NVEC; i++) begin
      handler_mode_i = VEC[i][17];
      ev_instr_unc_i = VEC[i][16];
      ev_async_unc_i = VEC[i][15];
      ev_iaccess_i   = VEC[i][14];
      ev_daccess_i   = VEC[i][13];
      end_method_i   = VEC[i][12:11];
      wdog_to_i      = VEC[i][10];
      priv_i         = VEC[i][9];
      priv_corrupt_i = VEC[i][8];
      @(negedge clk);
      idle_inputs();
      chk(trap_single_o == VEC[i][7], "R1 single pulse", {31'b0, trap_single_o}, {31'b0, VEC[i][7]});
      chk(trap_multi_o == VEC[i][6], "R2 multi pulse", {31'b0, trap_multi_o}, {31'b0, VEC[i][6]});
      @(negedge clk);
      chk(!(trap_single_o || trap_multi_o), "R8 pulse lasts one cycle",
          {31'b0, trap_single_o | trap_multi_o}, 0);
      chk(rd_data_o == prev, "R10 old value before update", rd_data_o, prev);
      @(negedge clk);
      expw = {26'b0, VEC[i][5:0]};
      chk(rd_data_o == expw, "R3 R4 R5 R6 R7 R8 status", rd_data_o, expw);
      prev = expw;
    end

    // R10: read disabled returns zero (status is 100000 here)
    rd_en_i = 1'b0;
    @(negedge clk);
    chk(rd_data_o == '0, "R10 read disabled", rd_data_o, 0);
    rd_en_i = 1'b1;
    @(negedge clk);
    chk(rd_data_o == 32'h20, "R10 read re-enabled", rd_data_o, 32'h20);

    // R9: reset while a trap is requested
    rst = 1'b1;
    ev_instr_unc_i = 1'b1;
    @(negedge clk);
    chk(!trap_single_o && !trap_multi_o, "R9 trap suppressed by reset",
        {31'b0, trap_single_o | trap_multi_o}, 0);
    idle_inputs();
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(rd_data_o == '0, "R9 status cleared by reset", rd_data_o, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule